// File: doc/BRIEF.md
# Load-Store Address and Alignment Unit

This unit sits in the memory stage of a 32-bit, byte-addressed, big-endian integer pipeline. For each memory instruction it forms the effective address from a base register value and a signed 16-bit displacement. It checks whole-word accesses for natural alignment and presents a word-aligned address to the data memory. When the aligned word comes back, the unit produces the value to write to the destination register.

Besides plain word loads and stores, the unit handles two partial-word load kinds. Together they let software assemble a word that crosses a word boundary. Each partial load reads only the aligned word that holds the addressed byte. It moves the relevant bytes into the correct lanes and keeps the other bytes of the old destination value, so no misaligned memory access is ever made. Address translation, caching and translation faults belong to other blocks.

The request is registered on one clock edge, and the memory address or address error appears in the following cycle. Memory returns its word combinationally in that cycle. The register write value appears one cycle after the address.

Top module: `lsu_addr_align`

## Requirements
- R1: The effective address equals the base value plus the sign-extended 16-bit offset. The memory address output is that sum with its two low bits forced to zero. It is valid in the cycle after the request is accepted.
- R2: For access kind 2'b00 (word load) or 2'b01 (word store), a sum whose two low bits are not both zero raises `addr_err_o` in the address cycle. In that case `mem_req_o` stays low and no register write follows.
- R3: An aligned word load returns the memory word unchanged on `wb_data_o`, with `wb_valid_o` high, one cycle after the address cycle.
- R4: Kind 2'b10 (high fill), at byte offset k inside the aligned word, places memory bytes k through 3 into the register's most significant bytes, in order. The remaining low k bytes keep the old register value. Byte 0 is the most significant byte of a word.
- R5: Kind 2'b11 (low fill), at byte offset k, places memory bytes 0 through k into the register's least significant bytes, in order. The remaining upper 3-k bytes keep the old register value.
- R6: Partial loads (kinds 2'b10 and 2'b11) never raise `addr_err_o`, whatever the low address bits.
- R7: An aligned word store drives `mem_req_o` and `mem_we_o` high in the address cycle and produces no register write.
- R8: A low fill at address 6 followed by a high fill at address 3 builds the value whose bytes, from most to least significant, are memory bytes 3, 4, 5 and 6. The second fill uses the first fill's result as its old register value.
- R9: While reset is asserted, and after it until a request is accepted, `mem_req_o`, `mem_we_o`, `addr_err_o` and `wb_valid_o` are low.
- R10: A cycle with no request produces no memory request and no address error in the next cycle, and no register write one cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A memory instruction is present this cycle |
| req_kind_i | input | 2 | 00 word load, 01 word store, 10 high fill, 11 low fill |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| old_val_i | input | 32 | Current destination register value |
| mem_rdata_i | input | 32 | Aligned word from memory during the address cycle |
| mem_req_o | output | 1 | Memory access is requested |
| mem_we_o | output | 1 | Requested access is a write |
| mem_addr_o | output | 32 | Word-aligned memory address |
| addr_err_o | output | 1 | Misaligned word access detected |
| wb_valid_o | output | 1 | Register write value is valid |
| wb_data_o | output | 32 | Register write value |

## Verification
Several properties hold on every clock cycle. The memory address has clear low bits and traces back to the previous cycle's base plus offset. An error never appears together with a memory request. Errors and stores are never followed by a register write. Every register write follows a read request. Partial loads never produce an error. An idle cycle leaves the outputs quiet. The byte placement of the two fill kinds cannot be seen by those properties and is shown only by the bench scenarios. These include every byte offset for both kinds, word data under negative displacements, and the two-step unaligned assembly that must yield bytes 3 to 6.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        ACC_WORD_LD = 2'b00,
        ACC_WORD_ST = 2'b01,
        ACC_FILL_HI = 2'b10,
        ACC_FILL_LO = 2'b11
    } acc_kind_e;

endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
    import lsu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  base_i,
    input  logic [IMM_W-1:0] offset_i,
    input  acc_kind_e        kind_i,
    output logic [XLEN-1:0]  ea_o,
    output logic             misaligned_o
);
    localparam int NB    = XLEN / 8;
    localparam int OFS_W = $clog2(NB);

    logic [XLEN-1:0] sext_ofs;
    logic            whole_word;

    always_comb begin
        sext_ofs     = {{(XLEN-IMM_W){offset_i[IMM_W-1]}}, offset_i};
        ea_o         = base_i + sext_ofs;
        // Only whole-word kinds carry an alignment rule.
        whole_word   = (kind_i == ACC_WORD_LD) || (kind_i == ACC_WORD_ST);
        misaligned_o = whole_word && (ea_o[OFS_W-1:0] != '0);
    end

endmodule

// File: rtl/lsu_byte_merge.sv
module lsu_byte_merge
    import lsu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  acc_kind_e                     kind_i,
    input  logic [$clog2(XLEN/8)-1:0]     ofs_i,
    input  logic [XLEN-1:0]               mem_word_i,
    input  logic [XLEN-1:0]               old_i,
    output logic [XLEN-1:0]               merged_o
);
    localparam int NB = XLEN / 8;

    // Lane i counts from the most significant byte (big endian).
    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [7:0] lane_b;
        int         src;
        logic       take;

        always_comb begin
            unique case (kind_i)
                ACC_FILL_HI: begin
                    src  = i + int'(ofs_i);
                    take = (src <= NB - 1);
                end
                ACC_FILL_LO: begin
                    src  = i - (NB - 1 - int'(ofs_i));
                    take = (src >= 0);
                end
                default: begin
                    src  = i;
                    take = 1'b1;
                end
            endcase
            if (take) begin
                lane_b = 8'(mem_word_i >> (8 * (NB - 1 - src)));
            end else begin
                lane_b = old_i[XLEN-1-8*i -: 8];
            end
        end

        assign merged_o[XLEN-1-8*i -: 8] = lane_b;
    end

endmodule

// File: rtl/lsu_addr_align.sv
module lsu_addr_align
    import lsu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_valid_i,
    input  logic [1:0]       req_kind_i,
    input  logic [XLEN-1:0]  base_i,
    input  logic [IMM_W-1:0] offset_i,
    input  logic [XLEN-1:0]  old_val_i,
    input  logic [XLEN-1:0]  mem_rdata_i,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [XLEN-1:0]  mem_addr_o,
    output logic             addr_err_o,
    output logic             wb_valid_o,
    output logic [XLEN-1:0]  wb_data_o
);
    localparam int NB    = XLEN / 8;
    localparam int OFS_W = $clog2(NB);

    typedef struct packed {
        logic            s1_vld;
        acc_kind_e       s1_kind;
        logic [XLEN-1:0] s1_ea;
        logic            s1_err;
        logic [XLEN-1:0] s1_old;
        logic            s2_vld;
        logic [XLEN-1:0] s2_data;
    } state_t;

    state_t          st_d, st_q;
    acc_kind_e       kind_in;
    logic [XLEN-1:0] ea_calc;
    logic            misal_calc;
    logic [XLEN-1:0] merged;

    assign kind_in = acc_kind_e'(req_kind_i);

    lsu_ea_gen #(
        .XLEN (XLEN),
        .IMM_W(IMM_W)
    ) i_ea_gen (
        .base_i      (base_i),
        .offset_i    (offset_i),
        .kind_i      (kind_in),
        .ea_o        (ea_calc),
        .misaligned_o(misal_calc)
    );

    lsu_byte_merge #(
        .XLEN(XLEN)
    ) i_merge (
        .kind_i    (st_q.s1_kind),
        .ofs_i     (st_q.s1_ea[OFS_W-1:0]),
        .mem_word_i(mem_rdata_i),
        .old_i     (st_q.s1_old),
        .merged_o  (merged)
    );

    always_comb begin
        st_d         = st_q;
        st_d.s1_vld  = req_valid_i;
        st_d.s1_kind = kind_in;
        st_d.s1_ea   = ea_calc;
        st_d.s1_err  = req_valid_i && misal_calc;
        st_d.s1_old  = old_val_i;
        st_d.s2_vld  = st_q.s1_vld && !st_q.s1_err && (st_q.s1_kind != ACC_WORD_ST);
        if (st_q.s1_vld) begin
            st_d.s2_data = merged;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req_o  = st_q.s1_vld && !st_q.s1_err;
    assign mem_we_o   = mem_req_o && (st_q.s1_kind == ACC_WORD_ST);
    assign mem_addr_o = {st_q.s1_ea[XLEN-1:OFS_W], {OFS_W{1'b0}}};
    assign addr_err_o = st_q.s1_vld && st_q.s1_err;
    assign wb_valid_o = st_q.s2_vld;
    assign wb_data_o  = st_q.s2_data;

endmodule

// File: rtl/lsu_addr_align_chk.sv
module lsu_addr_align_chk #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             req_valid_i,
    input logic [1:0]       req_kind_i,
    input logic [XLEN-1:0]  base_i,
    input logic [IMM_W-1:0] offset_i,
    input logic             mem_req_o,
    input logic             mem_we_o,
    input logic [XLEN-1:0]  mem_addr_o,
    input logic             addr_err_o,
    input logic             wb_valid_o
);
    localparam int OFS_W = $clog2(XLEN / 8);

    logic [XLEN-1:0] sum_ref;
    assign sum_ref = base_i + {{(XLEN-IMM_W){offset_i[IMM_W-1]}}, offset_i};

    assert_addr_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |-> (mem_addr_o[OFS_W-1:0] == '0));

    assert_addr_value_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |-> (mem_addr_o[XLEN-1:OFS_W] == $past(sum_ref[XLEN-1:OFS_W])));

    assert_err_blocks_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_err_o |-> !mem_req_o);

    assert_err_no_wb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_err_o |=> !wb_valid_o);

    assert_wb_after_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wb_valid_o |-> $past(mem_req_o && !mem_we_o));

    assert_part_no_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_kind_i[1]) |=> !addr_err_o);

    assert_store_no_wb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_we_o) |=> !wb_valid_o);

    assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> (!mem_req_o && !addr_err_o));

endmodule

bind lsu_addr_align lsu_addr_align_chk #(
    .XLEN (XLEN),
    .IMM_W(IMM_W)
) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_kind_i (req_kind_i),
    .base_i     (base_i),
    .offset_i   (offset_i),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .addr_err_o (addr_err_o),
    .wb_valid_o (wb_valid_o)
);

// File: tb/test_lsu_addr_align.sv
module test_lsu_addr_align;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [31:0] base = '0;
    logic [15:0] offset = '0;
    logic [31:0] old_val = '0;
    logic [31:0] mem_rdata;
    logic        mem_req, mem_we, addr_err, wb_valid;
    logic [31:0] mem_addr, wb_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic        e_req;
        logic        e_we;
        logic        e_err;
        logic [31:0] e_addr;
        logic        e_wb;
        logic [31:0] e_data;
    } exp_t;

    exp_t  aq[$];
    string atq[$];
    exp_t  wq[$];
    string wtq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_addr_align i_lsu_addr_align (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .req_valid_i(req_valid),
        .req_kind_i (req_kind),
        .base_i     (base),
        .offset_i   (offset),
        .old_val_i  (old_val),
        .mem_rdata_i(mem_rdata),
        .mem_req_o  (mem_req),
        .mem_we_o   (mem_we),
        .mem_addr_o (mem_addr),
        .addr_err_o (addr_err),
        .wb_valid_o (wb_valid),
        .wb_data_o  (wb_data)
    );

    // Memory image: one byte value per address, big-endian words.
    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return (a[7:0] * 8'd37) ^ 8'hC3 ^ a[15:8];
    endfunction

    function automatic logic [31:0] mword(input logic [31:0] a);
        logic [31:0] al;
        al = {a[31:2], 2'b00};
        return {mbyte(al), mbyte(al + 1), mbyte(al + 2), mbyte(al + 3)};
    endfunction

    always_comb mem_rdata = mword(mem_addr);

    function automatic logic [31:0] ref_value(input logic [1:0] kind,
                                              input logic [31:0] ea,
                                              input logic [31:0] old);
        logic [7:0]  r [4];
        logic [31:0] al;
        int          k;
        al = {ea[31:2], 2'b00};
        k  = int'(ea[1:0]);
        for (int j = 0; j < 4; j++) r[j] = old[31-8*j -: 8];
        case (kind)
            2'b10: for (int j = k; j < 4; j++) r[j-k] = mbyte(al + 32'(j));
            2'b11: for (int j = 0; j <= k; j++) r[3-k+j] = mbyte(al + 32'(j));
            default: for (int j = 0; j < 4; j++) r[j] = mbyte(al + 32'(j));
        endcase
        return {r[0], r[1], r[2], r[3]};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] kind, input logic [31:0] b,
                         input logic [15:0] ofs, input logic [31:0] old,
                         input string tag, input bit use_ovr = 1'b0,
                         input logic [31:0] ovr = '0);
        exp_t        e;
        logic [31:0] ea;
        @(negedge clk);
        #2;
        ea       = b + {{16{ofs[15]}}, ofs};
        e.e_err  = (kind[1] == 1'b0) && (ea[1:0] != 2'b00);
        e.e_req  = !e.e_err;
        e.e_we   = !e.e_err && (kind == 2'b01);
        e.e_addr = {ea[31:2], 2'b00};
        e.e_wb   = !e.e_err && (kind != 2'b01);
        e.e_data = use_ovr ? ovr : ref_value(kind, ea, old);
        req_valid = 1'b1;
        req_kind  = kind;
        base      = b;
        offset    = ofs;
        old_val   = old;
        aq.push_back(e);
        atq.push_back(tag);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        #2;
        e = '{e_req: 1'b0, e_we: 1'b0, e_err: 1'b0, e_addr: '0, e_wb: 1'b0, e_data: '0};
        req_valid = 1'b0;
        base      = 32'hDEAD_BEEF;
        aq.push_back(e);
        atq.push_back(tag);
    endtask

    // Monitor: address stage for the item sampled at the previous edge,
    // write-back stage one cycle later.
    initial begin
        forever begin
            @(negedge clk);
            if (wq.size() > 0) begin
                exp_t  e;
                string t;
                logic [35:0] act, exp;
                e = wq.pop_front();
                t = wtq.pop_front();
                act = {3'b0, wb_valid, e.e_wb ? wb_data : 32'h0};
                exp = {3'b0, e.e_wb, e.e_wb ? e.e_data : 32'h0};
                check(act == exp, t, "writeback", act, exp);
            end
            if (aq.size() > 0) begin
                exp_t  e;
                string t;
                logic [35:0] act, exp;
                e = aq.pop_front();
                t = atq.pop_front();
                act = {1'b0, mem_req, mem_we, addr_err, e.e_req ? mem_addr : 32'h0};
                exp = {1'b0, e.e_req, e.e_we, e.e_err, e.e_req ? e.e_addr : 32'h0};
                check(act == exp, t, "address", act, exp);
                wq.push_back(e);
                wtq.push_back(t);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] part;
        // R9: reset state, during and after reset
        repeat (2) @(negedge clk);
        check({mem_req, mem_we, addr_err, wb_valid} == 4'b0, "R9", "in reset",
              36'({mem_req, mem_we, addr_err, wb_valid}), 36'h0);
        @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({mem_req, mem_we, addr_err, wb_valid} == 4'b0, "R9", "after reset",
              36'({mem_req, mem_we, addr_err, wb_valid}), 36'h0);

        // R3 / R1: aligned word loads, positive and negative offsets
        issue(2'b00, 32'h0000_1000, 16'h0008, 32'h1111_1111, "R3");
        issue(2'b00, 32'h0000_2000, 16'hFFF0, 32'h2222_2222, "R1");
        issue(2'b00, 32'h0001_0003, 16'h0001, 32'h0, "R1");
        // R7: aligned stores, one with negative offset
        issue(2'b01, 32'h0000_0100, 16'hFFFC, 32'h0, "R7");
        issue(2'b01, 32'h0000_3000, 16'h0010, 32'h0, "R7");
        // R2: misaligned word load and store
        issue(2'b00, 32'h0000_1000, 16'h0001, 32'h0, "R2");
        issue(2'b01, 32'h0000_1002, 16'h0000, 32'h0, "R2");
        issue(2'b00, 32'h0000_1004, 16'hFFFF, 32'h0, "R2");
        idle("R10");
        idle("R10");
        // R4 / R5 / R6: every byte offset, both fill kinds
        for (int k = 0; k < 4; k++)
            issue(2'b10, 32'h0000_0040, 16'(k), 32'hA1B2_C3D4, k == 0 ? "R4" : "R6");
        for (int k = 0; k < 4; k++)
            issue(2'b11, 32'h0000_0080, 16'(k), 32'h5566_7788, k == 0 ? "R5" : "R6");
        issue(2'b10, 32'h0000_0205, 16'hFFFC, 32'h0F0E_0D0C, "R4");
        issue(2'b11, 32'h0000_0301, 16'h0001, 32'hF0E0_D0C0, "R5");
        // R8: low fill at 6, then high fill at 3
        part = ref_value(2'b11, 32'd6, 32'hCAFE_F00D);
        issue(2'b11, 32'h0, 16'd6, 32'hCAFE_F00D, "R8");
        issue(2'b10, 32'h0, 16'd3, part, "R8", 1'b1,
              {mbyte(32'd3), mbyte(32'd4), mbyte(32'd5), mbyte(32'd6)});
        idle("R10");
        repeat (3) @(negedge clk);
        while (aq.size() > 0 || wq.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule